// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Flags and Timed Flush

This block holds two byte queues between a register bus and a serial master engine. The transmit queue is filled from the bus side and drained by the engine. The receive queue is filled by the engine and drained from the bus side. Each queue shows its next byte on its read port before it is popped. Each queue has a 4-bit threshold register. The level flags derived from those thresholds let an interrupt block ask for refills and burst reads. The block also exports a one-cycle overrun event for the transmit side.

Software clears a queue by writing a 1 to that queue's flush bit in a control word. The bit reads back as set while the flush runs. Each queue has its own sequencer with three states:

- FL_IDLE: nothing to do. Transition IDLE→HOLD when the request bit is seen.
- FL_HOLD: counts the fixed flush time. Transition HOLD→DONE when the count ends.
- FL_DONE: zeroes the queue and drops the request. Transition DONE→IDLE unconditionally.

While a request is set, that queue ignores its own pushes and pops, so software polls the bit before it touches the queue again.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset both queues are empty and both flush requests are clear. Both thresholds are 0 and the overrun event is low. The flags are tx_empty=1, tx_near_empty=1, tx_full=0, rx_empty=1, rx_near_full=1 and rx_full=0.
- R2: Each queue returns bytes in the order they were accepted. The read data port always shows the oldest stored byte while the queue is not empty.
- R3: A push into a queue holding 16 bytes is dropped and leaves its contents unchanged. A pop from an empty queue has no effect.
- R4: tx_overrun is high for exactly the one cycle after a clock edge at which bus_tx_push was high while the transmit queue held 16 bytes and no transmit flush was pending.
- R5: tx_near_empty is high exactly when the transmit occupancy is less than or equal to the transmit threshold.
- R6: rx_near_full is high exactly when the receive occupancy is greater than or equal to the receive threshold.
- R7: tx_empty and rx_empty mean occupancy 0. tx_full means 16 stored bytes. rx_full means at least 15 stored bytes, which is a full 15-byte burst.
- R8: When ctl_we is high, a 1 in ctl_wdata bit 7 requests a transmit flush and a 1 in bit 8 requests a receive flush. Zeros in those bits and all other bits have no effect.
- R9: A flush request set at edge E reads high until edge E+5. At edge E+5 it clears and its queue becomes empty in the same edge. A new request written at that edge sets the bit again.
- R10: While a queue's flush request is high, pushes and pops on that queue are ignored and raise no overrun. The other queue keeps working.
- R11: A push and a pop on the same queue in one cycle both take effect when the queue is neither empty nor full. When the queue is full, the pop takes effect and the push is dropped.
- R12: thr_tx_we and thr_rx_we load thr_wdata[3:0] into the transmit and receive threshold at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word (bit 7 flushes transmit, bit 8 flushes receive) |
| thr_tx_we | input | 1 | Load transmit threshold |
| thr_rx_we | input | 1 | Load receive threshold |
| thr_wdata | input | 4 | Threshold value |
| bus_tx_push | input | 1 | Bus pushes a byte into the transmit queue |
| bus_tx_data | input | 8 | Byte to push into the transmit queue |
| eng_tx_pop | input | 1 | Engine takes the head of the transmit queue |
| eng_tx_data | output | 8 | Head of the transmit queue |
| eng_rx_push | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Received byte |
| bus_rx_pop | input | 1 | Bus takes the head of the receive queue |
| bus_rx_data | output | 8 | Head of the receive queue |
| tx_flush_busy | output | 1 | Transmit flush request bit |
| rx_flush_busy | output | 1 | Receive flush request bit |
| tx_empty | output | 1 | Transmit queue empty |
| tx_near_empty | output | 1 | Transmit occupancy at or below its threshold |
| tx_full | output | 1 | Transmit queue holds 16 bytes |
| tx_overrun | output | 1 | Push into a full transmit queue (one-cycle event) |
| rx_empty | output | 1 | Receive queue empty |
| rx_near_full | output | 1 | Receive occupancy at or above its threshold |
| rx_full | output | 1 | Receive queue holds 15 or more bytes |

## Verification
Two collisions are provoked, both directly and by random traffic. The first is a push and a pop landing on the same queue in one cycle, including on a full queue, where the push must be dropped and the transmit overrun event must fire. The second is a flush request arriving in the same cycle as a push, or as the finishing edge of an earlier flush: the push must land before the flush wipes the queue, and the request must re-arm. A bench model that steps once per clock edge predicts the queue contents, the request bits and the overrun event. Every flag and head byte is compared against that model on each falling edge.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_HOLD = 2'd1,
        FL_DONE = 2'd2
    } flush_state_e;

    localparam int unsigned TX_FLUSH_BIT = 7;
    localparam int unsigned RX_FLUSH_BIT = 8;

endpackage

// File: rtl/i2cq_byte_fifo.sv
module i2cq_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             freeze,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    pop_data,
    output logic [CNT_W-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0]    mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_full, is_empty, push_ok, pop_ok;

    assign is_full  = (cnt_q == CNT_W'(DEPTH));
    assign is_empty = (cnt_q == '0);
    assign push_ok  = push & ~freeze & ~is_full;
    assign pop_ok   = pop & ~freeze & ~is_empty;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) begin
                wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            end
            if (pop_ok) begin
                rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && !clr && push_ok) begin
            mem[wptr_q] <= push_data;
        end
    end

    assign pop_data = mem[rptr_q];
    assign count    = cnt_q;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)) else $error("occupancy beyond depth"); // R7

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && is_full) |=> (cnt_q == CNT_W'(DEPTH))) else $error("push into full queue changed it"); // R3

endmodule

// File: rtl/i2cq_flush_seq.sv
module i2cq_flush_seq
    import i2cq_pkg::*;
#(
    parameter int FLUSH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic req,
    output logic clr
);
    localparam int CW   = (FLUSH_CYC > 2) ? $clog2(FLUSH_CYC) : 1;
    localparam int LAST = (FLUSH_CYC > 2) ? FLUSH_CYC - 2 : 0;

    flush_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == FL_HOLD && state_d == FL_HOLD) ? cnt_q + 1'b1 : '0;
            req_q   <= (req_q & ~clr) | set_req;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (req_q) state_d = FL_HOLD;
            FL_HOLD: if (cnt_q == CW'(LAST)) state_d = FL_DONE;
            FL_DONE: state_d = FL_IDLE;
            default: state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        clr = 1'b0;
        unique case (state_q)
            FL_DONE: clr = 1'b1;
            default: clr = 1'b0;
        endcase
    end

    assign req = req_q;

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FL_IDLE) |-> req_q) else $error("sequencer active without request"); // R9

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_DONE) |=> (!req_q || $past(set_req))) else $error("request survived its flush"); // R9

endmodule

// File: rtl/i2cq_level_flags.sv
module i2cq_level_flags #(
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 5,
    parameter int THR_W     = 4,
    parameter bit NEAR_LOW  = 1'b1,
    parameter int FULL_MARK = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thr,
    output logic             empty,
    output logic             near,
    output logic             full
);
    logic [CNT_W-1:0] thr_ext;
    assign thr_ext = CNT_W'(thr);

    assign empty = (count == '0);
    assign full  = (count >= CNT_W'(FULL_MARK));

    generate
        if (NEAR_LOW) begin : g_near_low
            assign near = (count <= thr_ext);
        end else begin : g_near_high
            assign near = (count >= thr_ext);
        end
    endgenerate

    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)) else $error("empty and full together"); // R7

    AST_DEPTH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)) else $error("count out of range"); // R7

endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
    import i2cq_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DEPTH     = 16,
    parameter int THR_W     = 4,
    parameter int CTL_W     = 16,
    parameter int FLUSH_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             thr_tx_we,
    input  logic             thr_rx_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             bus_tx_push,
    input  logic [DW-1:0]    bus_tx_data,
    input  logic             eng_tx_pop,
    output logic [DW-1:0]    eng_tx_data,
    input  logic             eng_rx_push,
    input  logic [DW-1:0]    eng_rx_data,
    input  logic             bus_rx_pop,
    output logic [DW-1:0]    bus_rx_data,
    output logic             tx_flush_busy,
    output logic             rx_flush_busy,
    output logic             tx_empty,
    output logic             tx_near_empty,
    output logic             tx_full,
    output logic             tx_overrun,
    output logic             rx_empty,
    output logic             rx_near_full,
    output logic             rx_full
);
    localparam int CNT_W        = $clog2(DEPTH + 1);
    localparam int RX_FULL_MARK = (2 ** THR_W) - 1;

    logic [THR_W-1:0] tx_thr_q, rx_thr_q;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_req, rx_req, tx_clr, rx_clr;
    logic             tx_set, rx_set, tx_ovr_q;

    assign tx_set = ctl_we & ctl_wdata[TX_FLUSH_BIT];
    assign rx_set = ctl_we & ctl_wdata[RX_FLUSH_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= '0;
            tx_ovr_q <= 1'b0;
        end else begin
            if (thr_tx_we) tx_thr_q <= thr_wdata;
            if (thr_rx_we) rx_thr_q <= thr_wdata;
            tx_ovr_q <= bus_tx_push & ~tx_req & (tx_cnt == CNT_W'(DEPTH));
        end
    end

    i2cq_flush_seq #(.FLUSH_CYC(FLUSH_CYC)) u_tx_flush (
        .clk(clk), .rst_n(rst_n), .set_req(tx_set), .req(tx_req), .clr(tx_clr)
    );

    i2cq_flush_seq #(.FLUSH_CYC(FLUSH_CYC)) u_rx_flush (
        .clk(clk), .rst_n(rst_n), .set_req(rx_set), .req(rx_req), .clr(rx_clr)
    );

    i2cq_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .freeze(tx_req),
        .push(bus_tx_push), .push_data(bus_tx_data),
        .pop(eng_tx_pop), .pop_data(eng_tx_data), .count(tx_cnt)
    );

    i2cq_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .freeze(rx_req),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(bus_rx_pop), .pop_data(bus_rx_data), .count(rx_cnt)
    );

    i2cq_level_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W),
                       .NEAR_LOW(1'b1), .FULL_MARK(DEPTH)) u_tx_flags (
        .clk(clk), .rst_n(rst_n), .count(tx_cnt), .thr(tx_thr_q),
        .empty(tx_empty), .near(tx_near_empty), .full(tx_full)
    );

    i2cq_level_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W),
                       .NEAR_LOW(1'b0), .FULL_MARK(RX_FULL_MARK)) u_rx_flags (
        .clk(clk), .rst_n(rst_n), .count(rx_cnt), .thr(rx_thr_q),
        .empty(rx_empty), .near(rx_near_full), .full(rx_full)
    );

    assign tx_flush_busy = tx_req;
    assign rx_flush_busy = rx_req;
    assign tx_overrun    = tx_ovr_q;

    AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_req) |-> (tx_cnt == '0)) else $error("tx not empty after flush"); // R9

    AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_req) |-> (rx_cnt == '0)) else $error("rx not empty after flush"); // R9

    AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_clr) |=> $stable(tx_cnt)) else $error("tx moved during flush"); // R10

    AST_RX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && !rx_clr) |=> $stable(rx_cnt)) else $error("rx moved during flush"); // R10

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overrun |-> $past(bus_tx_push && tx_full && !tx_flush_busy)) else $error("overrun without cause"); // R4

endmodule

// File: tb/i2c_fifo_pair_tb_top.sv
module i2c_fifo_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        thr_tx_we = 1'b0, thr_rx_we = 1'b0;
    logic [3:0]  thr_wdata = '0;
    logic        bus_tx_push = 1'b0, eng_tx_pop = 1'b0;
    logic [7:0]  bus_tx_data = '0, eng_tx_data;
    logic        eng_rx_push = 1'b0, bus_rx_pop = 1'b0;
    logic [7:0]  eng_rx_data = '0, bus_rx_data;
    logic        tx_flush_busy, rx_flush_busy, tx_empty, tx_near_empty, tx_full, tx_overrun;
    logic        rx_empty, rx_near_full, rx_full;

    always #2 clk = ~clk;

    i2c_fifo_pair dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .thr_tx_we(thr_tx_we), .thr_rx_we(thr_rx_we), .thr_wdata(thr_wdata),
        .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
        .tx_flush_busy(tx_flush_busy), .rx_flush_busy(rx_flush_busy),
        .tx_empty(tx_empty), .tx_near_empty(tx_near_empty), .tx_full(tx_full),
        .tx_overrun(tx_overrun), .rx_empty(rx_empty), .rx_near_full(rx_near_full),
        .rx_full(rx_full)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [7:0] mtx[$];
    logic [7:0] mrx[$];
    bit         m_txreq = 0, m_rxreq = 0, m_ovr = 0;
    int         m_txtm = 0, m_rxtm = 0;
    logic [3:0] m_tthr = 0, m_rthr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit f_near_empty(int sz, logic [3:0] t); return sz <= int'(t); endfunction
    function automatic bit f_near_full(int sz, logic [3:0] t);  return sz >= int'(t); endfunction

    task automatic check_all();
        int ts = mtx.size();
        int rs = mrx.size();
        chk(tx_empty == (ts == 0), "R7 tx_empty", tx_empty, ts == 0);
        chk(tx_full == (ts == 16), "R7 tx_full", tx_full, ts == 16);
        chk(tx_near_empty == f_near_empty(ts, m_tthr), "R5 tx_near_empty", tx_near_empty, f_near_empty(ts, m_tthr));
        chk(tx_overrun == m_ovr, "R4 tx_overrun", tx_overrun, m_ovr);
        chk(rx_empty == (rs == 0), "R7 rx_empty", rx_empty, rs == 0);
        chk(rx_full == (rs >= 15), "R7 rx_full", rx_full, rs >= 15);
        chk(rx_near_full == f_near_full(rs, m_rthr), "R6 rx_near_full", rx_near_full, f_near_full(rs, m_rthr));
        chk(tx_flush_busy == m_txreq, "R9 tx_flush_busy", tx_flush_busy, m_txreq);
        chk(rx_flush_busy == m_rxreq, "R9 rx_flush_busy", rx_flush_busy, m_rxreq);
        if (ts > 0) chk(eng_tx_data == mtx[0], "R2 eng_tx_data", eng_tx_data, mtx[0]);
        if (rs > 0) chk(bus_rx_data == mrx[0], "R2 bus_rx_data", bus_rx_data, mrx[0]);
    endtask

    // One clock: drive, step the model to the post-edge state, then compare at the falling edge.
    task automatic step(input bit tp, input logic [7:0] td, input bit tq,
                        input bit rp, input logic [7:0] rd, input bit rq,
                        input bit cwe, input logic [15:0] cwd,
                        input bit twe, input bit rwe, input logic [3:0] twd);
        bit tpush_ok, tpop_ok, rpush_ok, rpop_ok, tset, rset;
        bus_tx_push = tp; bus_tx_data = td; eng_tx_pop = tq;
        eng_rx_push = rp; eng_rx_data = rd; bus_rx_pop = rq;
        ctl_we = cwe; ctl_wdata = cwd; thr_tx_we = twe; thr_rx_we = rwe; thr_wdata = twd;
        tset = cwe && cwd[7];
        rset = cwe && cwd[8];
        // transmit side (R3, R4, R10, R11)
        m_ovr = tp && !m_txreq && mtx.size() == 16;
        tpush_ok = tp && !m_txreq && mtx.size() < 16;
        tpop_ok  = tq && !m_txreq && mtx.size() > 0;
        if (tpop_ok) void'(mtx.pop_front());
        if (tpush_ok) mtx.push_back(td);
        rpush_ok = rp && !m_rxreq && mrx.size() < 16;
        rpop_ok  = rq && !m_rxreq && mrx.size() > 0;
        if (rpop_ok) void'(mrx.pop_front());
        if (rpush_ok) mrx.push_back(rd);
        // flush timing (R8, R9)
        if (m_txreq) begin
            m_txtm++;
            if (m_txtm == 5) begin mtx.delete(); m_txreq = tset; m_txtm = 0; end
        end else if (tset) begin m_txreq = 1; m_txtm = 0; end
        if (m_rxreq) begin
            m_rxtm++;
            if (m_rxtm == 5) begin mrx.delete(); m_rxreq = rset; m_rxtm = 0; end
        end else if (rset) begin m_rxreq = 1; m_rxtm = 0; end
        if (twe) m_tthr = twd; // R12
        if (rwe) m_rthr = twd;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h51c0ffee));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_empty && tx_near_empty && !tx_full && !tx_overrun, "R1 tx reset flags",
            {tx_empty, tx_near_empty, tx_full, tx_overrun}, 4'b1100);
        chk(rx_empty && rx_near_full && !rx_full && !tx_flush_busy && !rx_flush_busy,
            "R1 rx reset flags", {rx_empty, rx_near_full, rx_full, tx_flush_busy, rx_flush_busy}, 5'b11000);
        check_all();

        // R12 thresholds
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 4'd4);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd3);
        // R3 R4 R7: fill transmit queue beyond 16
        for (int i = 0; i < 18; i++) step(1, 8'(8'h40 + i), 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle();
        // R11: push and pop together on full queue
        step(1, 8'hEE, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 8'hED, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R11: push and pop together mid-level
        step(1, 8'hEC, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2 drain transmit
        for (int i = 0; i < 18; i++) step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3 pop on empty
        step(0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
        // receive fill to 17 tries, crossing threshold and full mark (R6 R7)
        for (int i = 0; i < 17; i++) step(0, 0, 0, 1, 8'(8'h90 + i), 0, 0, 0, 0, 0, 0);
        // R8: other bits only, no flush
        step(0, 0, 0, 0, 0, 0, 1, 16'hFE7F, 0, 0, 0);
        // R8 R9 R10: rx flush with push in same cycle, pops during flush
        step(0, 0, 0, 1, 8'h11, 1, 1, 16'h0100, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1, 8'(i), 0, 1, 8'h22, 1, 0, 0, 0, 0, 0);
        // R9: tx flush re-armed on its finishing edge
        step(1, 8'h33, 0, 0, 0, 0, 1, 16'h0080, 0, 0, 0);
        for (int i = 0; i < 4; i++) idle();
        step(0, 0, 0, 0, 0, 0, 1, 16'h0080, 0, 0, 0);
        for (int i = 0; i < 7; i++) step(1, 8'h44, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit tp = ($urandom % 100) < 55;
            bit tq = ($urandom % 100) < 40;
            bit rp = ($urandom % 100) < 50;
            bit rq = ($urandom % 100) < 45;
            bit cw = ($urandom % 100) < 3;
            bit tw = ($urandom % 100) < 4;
            bit rw = ($urandom % 100) < 4;
            step(tp, 8'($urandom), tq, rp, 8'($urandom), rq, cw, 16'($urandom),
                 tw, rw, 4'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule